// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects an on-chip request port to an external asynchronous 128K x 8 static RAM. A client presents one word request at a time, a read or a write, on a valid/ready handshake. The controller turns each request into the pin sequence that the memory expects. That sequence covers a 17-bit address, a low-true and a high-true chip select, a low-true write strobe, a low-true output enable, and a data bus that is split into an output word, an output-enable bit and an input word. The pad ring ties these three together into the bidirectional pins. Read data returns on a separate port together with a one-cycle valid pulse.

Each phase of an access lasts a whole number of clock cycles. That number is the minimum memory time divided by the clock period and rounded up. All of these times are parameters, so the same code suits other clocks and other speed grades. Between accesses the memory stays deselected, which keeps it in standby. After every read the controller adds a quiet gap, so the bus is never driven from both ends.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, all of the following hold: req_ready=1, mem_sel_n=1, mem_sel_p=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, rd_valid=0.
- R2: Whenever req_ready is high, the memory is deselected (mem_sel_n=1, mem_sel_p=0).
- R3: A read accepted at a clock edge drives mem_addr, mem_sel_n=0, mem_sel_p=1, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles. RD_CYC is the larger of ceil(T_RC/clk) and ceil(T_AA/clk), which is 7 at 8 ns. After those cycles the select and the output enable return to idle.
- R4: The value on mem_dq_in in the last cycle of the read window shows on rd_data in the next cycle, with rd_valid high for exactly that one cycle.
- R5: After a read window, req_ready stays low and mem_dq_oe stays low for TURN_CYC = max(1, ceil(T_OHZ/clk)) cycles, which is 4 by default.
- R6: A write accepted at a clock edge selects the chip and holds mem_we_n high for SU_CYC=1 cycle. It then holds mem_we_n low for WP_CYC = max(ceil(T_WP/clk), ceil(T_DW/clk)) cycles, which is 5, and then high for REC_CYC cycles. REC_CYC is at least 1 and is chosen so that the three phases together last at least ceil(T_WC/clk) cycles, which gives 7 in total.
- R7: During a write the data word is on mem_dq_out with mem_dq_oe=1 and mem_oe_n=1 for as long as the chip is selected. mem_dq_oe is never 1 outside a write, and mem_we_n is low only while the chip is selected.
- R8: mem_addr changes only when mem_we_n is high, both in the cycle of the change and in the cycle before it.
- R9: While req_ready is low, req_valid, req_write, req_addr and req_wdata have no effect on the memory pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds read result |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Low-true chip select |
| mem_sel_p | output | 1 | High-true chip select |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_dq_out | output | 8 | Data driven towards memory |
| mem_dq_oe | output | 1 | Enables the data pad drivers |
| mem_dq_in | input | 8 | Data read from the pads |

## Verification
Two events can fall close together on the bus. One is the memory releasing the bus after a read, and the other is the controller starting to drive write data. The bench provokes this by issuing a write as soon as req_ready returns after a read, and by holding a pending request during a read. A memory model in the bench flags any cycle in which it drives while mem_dq_oe is high. It also returns valid data only in the last cycle of the read window, so a capture in any other cycle returns a wrong value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } ctrl_state_t;

  // cycles needed to cover a time, rounded up
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) dout <= din;
    end
  end

  // R4: result strobe lasts a single cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 8000,
  parameter int T_RC_PS  = 55000,
  parameter int T_AA_PS  = 55000,
  parameter int T_OHZ_PS = 30000,
  parameter int T_AS_PS  = 0,
  parameter int T_WP_PS  = 35000,
  parameter int T_DW_PS  = 25000,
  parameter int T_WC_PS  = 55000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC   = max2(1, max2(cdiv(T_RC_PS, CLK_PS), cdiv(T_AA_PS, CLK_PS)));
  localparam int TURN_CYC = max2(1, cdiv(T_OHZ_PS, CLK_PS));
  localparam int SU_CYC   = max2(1, cdiv(T_AS_PS, CLK_PS));
  localparam int WP_CYC   = max2(1, max2(cdiv(T_WP_PS, CLK_PS), cdiv(T_DW_PS, CLK_PS)));
  localparam int WC_CYC   = cdiv(T_WC_PS, CLK_PS);
  localparam int REC_CYC  = max2(1, WC_CYC - SU_CYC - WP_CYC);
  localparam int MAX_CYC  = max2(max2(RD_CYC, TURN_CYC), max2(max2(SU_CYC, WP_CYC), REC_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_state_t      state_q, state_d;
  logic             tmr_load, tmr_done, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign capture = (state_q == ST_RD) && tmr_done;

  sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .din     (mem_dq_in),
    .dout    (rd_data),
    .valid   (rd_valid)
  );

  assign req_ready = (state_q == ST_IDLE);

  // next state and phase length
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WSETUP;
          tmr_val = CNT_W'(SU_CYC - 1);
        end else begin
          state_d = ST_RD;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: if (tmr_done) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TURN_CYC - 1);
      end
      ST_TURN: if (tmr_done) state_d = ST_IDLE;
      ST_WSETUP: if (tmr_done) begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: if (tmr_done) begin
        state_d  = ST_WREC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WREC: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // registered memory pins
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel_p  <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          mem_addr  <= req_addr;
          mem_sel_n <= 1'b0;
          mem_sel_p <= 1'b1;
          if (req_write) begin
            mem_dq_out <= req_wdata;
            mem_dq_oe  <= 1'b1;
          end else begin
            mem_oe_n <= 1'b0;
          end
        end
        ST_RD: if (tmr_done) begin
          mem_sel_n <= 1'b1;
          mem_sel_p <= 1'b0;
          mem_oe_n  <= 1'b1;
        end
        ST_WSETUP: if (tmr_done) mem_we_n <= 1'b0;
        ST_WPULSE: if (tmr_done) mem_we_n <= 1'b1;
        ST_WREC: if (tmr_done) begin
          mem_sel_n <= 1'b1;
          mem_sel_p <= 1'b0;
          mem_dq_oe <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // length of the current low strobe, for the pulse width check
  logic [CNT_W:0] we_low_len;
  always_ff @(posedge clk) begin
    if (rst)                    we_low_len <= '0;
    else if (mem_we_n)          we_low_len <= '0;
    else if (we_low_len != '1)  we_low_len <= we_low_len + 1'b1;
  end

  p_idle_standby_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && !mem_sel_p));

  p_read_quiet_bus_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_len >= (CNT_W+1)'(WP_CYC)));

  p_we_selected_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel_n && mem_sel_p && mem_dq_oe));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(mem_addr));
endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
  localparam int AW = 17, DW = 8, CLK = 8000;
  function automatic int ceil_c(input int t); return (t + CLK - 1) / CLK; endfunction
  localparam int RD   = (ceil_c(55000) > 1) ? ceil_c(55000) : 1;
  localparam int TURN = (ceil_c(30000) > 1) ? ceil_c(30000) : 1;
  localparam int SU   = 1;
  localparam int WP   = (ceil_c(35000) > ceil_c(25000)) ? ceil_c(35000) : ceil_c(25000);
  localparam int REC  = (ceil_c(55000) - SU - WP > 1) ? ceil_c(55000) - SU - WP : 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;  // 125 MHz

  sram_async_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  int checks = 0, errors = 0, conflicts = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and shadow copy
  bit [7:0] mem_q [int];
  bit [7:0] shadow [int];
  function automatic bit [7:0] init_val(input int a); return a[7:0] ^ 8'h5A; endfunction
  function automatic bit [7:0] mem_rd(input int a);
    return mem_q.exists(a) ? mem_q[a] : init_val(a);
  endfunction
  function automatic bit [7:0] exp_rd(input int a);
    return shadow.exists(a) ? shadow[a] : init_val(a);
  endfunction

  int rd_age = 0, wr_len = 0, wr_a = 0;
  bit [7:0] wr_d = 0;
  wire rd_act = !mem_sel_n && mem_sel_p && !mem_oe_n && mem_we_n;
  wire wr_act = !mem_sel_n && mem_sel_p && !mem_we_n;
  assign mem_dq_in = (rd_act && rd_age >= RD - 1) ? mem_rd(int'(mem_addr)) : 8'hEE;

  always @(posedge clk) begin
    if (!rst) begin
      rd_age <= rd_act ? rd_age + 1 : 0;
      if (rd_act && mem_dq_oe) conflicts++;
      if (wr_act) begin
        wr_len <= wr_len + 1;
        wr_a   <= int'(mem_addr);
        wr_d   <= mem_dq_out;
      end else if (wr_len != 0) begin
        mem_q[wr_a] = wr_d;
        chk(wr_len * CLK >= 35000 && wr_len * CLK >= 25000, "R6 pulse/data window", wr_len, WP);
        wr_len <= 0;
      end
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(input int a, input bit poke);
    bit ok = 1;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 0;
    if (poke) begin req_valid = 1; req_write = 1; req_addr = ~AW'(a); req_wdata = 8'h3C; end
    for (int i = 0; i < RD; i++) begin
      if (mem_sel_n || !mem_sel_p || mem_oe_n || !mem_we_n || mem_addr != AW'(a) ||
          mem_dq_oe || req_ready) ok = 0;
      if (i == RD - 2) req_valid = 0;
      @(negedge clk);
    end
    chk(ok, poke ? "R9 busy request ignored" : "R3 read window", int'(mem_addr), a);
    chk(mem_oe_n && mem_sel_n && !mem_sel_p, "R3 read end", {mem_oe_n, mem_sel_n, mem_sel_p}, 3'b110);
    chk(rd_valid && rd_data == exp_rd(a), "R4 read data", {rd_valid, rd_data}, {1'b1, exp_rd(a)});
    ok = 1;
    for (int i = 0; i < TURN; i++) begin
      if (req_ready || mem_dq_oe) ok = 0;
      if (i == 1 && rd_valid) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R5 turnaround gap", 0, 0);
    chk(req_ready && !rd_valid, "R5 ready after gap", {req_ready, rd_valid}, 2'b10);
  endtask

  task automatic do_write(input int a, input bit [7:0] d);
    bit ok7 = 1, ok6 = 1;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < SU + WP + REC; i++) begin
      if (mem_we_n != !(i >= SU && i < SU + WP)) ok6 = 0;
      if (mem_sel_n || !mem_sel_p || mem_addr != AW'(a) || req_ready) ok6 = 0;
      if (!mem_dq_oe || mem_dq_out != d || !mem_oe_n) ok7 = 0;
      @(negedge clk);
    end
    chk(ok6, "R6 write strobe sequence", int'(mem_addr), a);
    chk(ok7, "R7 write data driven", mem_dq_out, d);
    chk(req_ready && mem_sel_n && !mem_sel_p && !mem_dq_oe, "R2 standby after write",
        {req_ready, mem_sel_n, mem_sel_p, mem_dq_oe}, 4'b1100);
    shadow[a] = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready && mem_sel_n && !mem_sel_p && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
        "R1 reset state", {req_ready, mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid},
        7'b1101100);
    rst = 0;
    @(negedge clk);
    chk(req_ready && mem_sel_n && !mem_sel_p && !mem_dq_oe, "R1 after reset",
        {req_ready, mem_sel_n, mem_sel_p, mem_dq_oe}, 4'b1100);
    // directed corners
    do_read(5, 0);                 // unwritten location
    do_write(0, 8'hA1);
    do_read(0, 0);
    do_write(17'h1FFFF, 8'h7E);
    do_read(17'h1FFFF, 1);         // R9 with a pending request during the read
    do_write(17'h1FFFF, 8'h81);    // write right after a read (R5)
    do_read(17'h1FFFF, 0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      int a = 32'h100 + int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else do_read(a, $urandom_range(0, 3) == 0);
    end
    chk(conflicts == 0, "R7 no bus conflict", conflicts, 0);
    chk(mem_addr == mem_addr && mem_we_n, "R8 idle strobe high", mem_we_n, 1);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule